// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the 32-bit datapath of a processor that runs each instruction over several clock cycles. All phases share one ALU and one memory port. An external sequencer drives every select and enable as a port. Values that must survive from one phase to the next are held in internal registers:

- the fetched instruction,
- the word read from memory,
- the two register operands,
- the registered ALU result.

The datapath holds the program counter, a 32-entry register file, the ALU with its own function-field decoder, immediate extension and scaling, and the multiplexers for operands, addresses and write-back. Towards the sequencer it exports the opcode field and the ALU zero flag. Towards memory it exports a single address, write data and read data path. The memory and the sequencing of phases live outside the block.

A typical instruction works as follows:

1. A fetch phase latches the instruction and advances the PC by four through the ALU.
2. A decode phase latches both register operands and precomputes a branch target.
3. Later phases select an operand source, an ALU mode, a memory address source and a write-back target.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-low reset clears the PC, the instruction register, the memory data register, both operand registers, the ALU result register and every register-file entry, so that after reset `mem_addr`, `mem_wdata` and `opcode` read zero.
- R2: With `ir_wr` high, the instruction register loads `mem_rdata` at the clock edge. A fetch setting advances the PC from P to P+4 through the ALU: `src_a_sel`=0, `src_b_sel`=01, `alu_mode`=00, `pc_src`=00 and `pc_wr`=1.
- R3: On every clock edge the first operand register loads the register addressed by instruction bits [25:21], and the second loads the register addressed by bits [20:16]. With `src_a_sel`=0 and `src_b_sel`=11, the ALU result register receives PC + (sign-extended bits [15:0] << 2).
- R4: `mem_addr` shows the PC when `addr_sel`=0 and the ALU result register when `addr_sel`=1. `mem_wdata` always shows the second operand register.
- R5: The value written to the PC comes from one of three sources, chosen by `pc_src`:
  - 00: the live ALU result;
  - 01: the ALU result register;
  - 10: {PC[31:28], instruction bits [25:0], 2'b00}.
- R6: The PC is written when `pc_wr` is high, or when `pc_wr_cond` is high and `alu_zero` is 1. Otherwise it keeps its value.
- R7: With `reg_wr` high, the register file is written at the clock edge.
  - The write address is instruction bits [15:11] when `dst_sel`=1, and bits [20:16] when `dst_sel`=0.
  - The write data is the ALU result register when `wb_sel`=0, and the memory data register when `wb_sel`=1.
- R8: `alu_mode` 00 adds and 01 subtracts (second operand from first). `alu_zero` is 1 exactly when the live ALU result is zero.
- R9: With `alu_mode`=10, the operation is decoded from instruction bits [5:0]. 6'h20 adds, 6'h22 subtracts, 6'h24 is AND, 6'h25 is OR, and 6'h2A is a signed set-less-than giving 1 or 0. Any other code adds.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: The instruction register keeps its value while `ir_wr` is low. The memory data register, both operand registers and the ALU result register load on every clock edge.
- R12: `src_a_sel` picks the first ALU operand: 0 is the PC, 1 is the first operand register. `src_b_sel` picks the second operand:
  - 00: the second operand register;
  - 01: the constant 4;
  - 10: sign-extended bits [15:0];
  - 11: the same value shifted left by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_wr | input | 1 | Unconditional PC write enable |
| pc_wr_cond | input | 1 | PC write enable qualified by the zero flag |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU result register |
| ir_wr | input | 1 | Instruction register load enable |
| reg_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Write address field: 1 bits [15:11], 0 bits [20:16] |
| wb_sel | input | 1 | Write data source: 0 ALU result register, 1 memory data register |
| alu_mode | input | 2 | 00 add, 01 subtract, 10 function field |
| src_a_sel | input | 1 | First ALU operand: 0 PC, 1 first operand register |
| src_b_sel | input | 2 | Second ALU operand source, see R12 |
| pc_src | input | 2 | PC source, see R5 |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| opcode | output | 6 | Instruction bits [31:26] |
| alu_zero | output | 1 | Live ALU result equals zero |

## Verification
Register-based outputs change one edge after the stimulus:

- the PC seen on `mem_addr`, the ALU result register, `mem_wdata` and `opcode`;
- a register-file write, which first shows in the operand registers at the edge after the write, and on `mem_wdata` only through the second operand register.

`alu_zero` and the `mem_addr` source selection are combinational, so they follow the current select inputs within the same cycle. The bench drives each setting just after a falling edge. It advances a behavioural model at the rising edge and compares every output one nanosecond after that edge, while the inputs that caused the update are still applied. Directed value checks are placed after the specific phase whose edge produces the result. For example, an R-type result is read with `addr_sel`=1 right after the execute edge, before the next edge overwrites the ALU result register.

// File: rtl/mc_dp_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, select encodings and function-field codes for the
// multicycle datapath. Assumes a 32-bit instruction word with fixed fields.
package mc_dp_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_NUM = 32;
    localparam int REG_AW  = $clog2(REG_NUM);
    localparam int FN_W    = 6;

    // ALU mode from the sequencer
    typedef enum logic [1:0] {
        AM_ADD  = 2'b00,
        AM_SUB  = 2'b01,
        AM_FUNC = 2'b10
    } alu_mode_e;

    // Second ALU operand source
    typedef enum logic [1:0] {
        SB_REG    = 2'b00,
        SB_FOUR   = 2'b01,
        SB_IMM    = 2'b10,
        SB_IMM_X4 = 2'b11
    } src_b_e;

    // PC input source
    typedef enum logic [1:0] {
        PS_ALU  = 2'b00,
        PS_HELD = 2'b01,
        PS_JUMP = 2'b10
    } pc_src_e;

    // Internal ALU operation after decoding
    typedef enum logic [2:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_SLT
    } alu_op_e;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
// Module: mc_regfile
// Two combinational read ports and one synchronous write port. Entry 0 is
// held at zero and ignores writes. Every entry clears on synchronous reset.
// Assumes the writer and both readers share one clock.
module mc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_addr,
    input  logic [AW-1:0] rd_b_addr,
    output logic [W-1:0]  rd_a_data,
    output logic [W-1:0]  rd_b_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] regs [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [AW-1:0] IDX     = AW'(i);
        localparam bit            IS_ZERO = (i == 0);
        // Per-entry storage: cleared on reset, entry 0 pinned to zero
        always_ff @(posedge clk) begin
            if (!rst_n || IS_ZERO) begin
                regs[i] <= '0;
            end else if (we && wr_addr == IDX) begin
                regs[i] <= wr_data;
            end
        end
    end

    // Read ports with an explicit zero for address 0
    always_comb begin
        rd_a_data = (rd_a_addr == '0) ? '0 : regs[rd_a_addr];
        rd_b_data = (rd_b_addr == '0) ? '0 : regs[rd_b_addr];
    end

    // R10
    rf_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0));

    // R7
    rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_addr != '0) |=> (regs[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
// Module: mc_alu
// Combinational ALU with its local function-field decoder. The mode picks
// add, subtract, or an operation taken from the function field. Unknown
// function codes fall back to add. Set-less-than compares signed values.
module mc_alu
    import mc_dp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [1:0]      mode,
    input  logic [FN_W-1:0] funct,
    output logic [W-1:0]    result,
    output logic            zero
);

    alu_op_e op;

    // Local decoder: mode and function field to an operation
    always_comb begin
        op = OP_ADD;
        case (mode)
            AM_SUB: op = OP_SUB;
            AM_FUNC: begin
                case (funct)
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_SLT:  op = OP_SLT;
                    default: op = OP_ADD;
                endcase
            end
            default: op = OP_ADD;
        endcase
    end

    // Arithmetic and logic unit proper
    always_comb begin
        case (op)
            OP_SUB:  result = a - b;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_SLT:  result = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: result = a + b;
        endcase
    end

    // Zero flag for conditional PC writes
    always_comb zero = (result == '0);

endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
// Module: mc_datapath
// Datapath of a multicycle processor with one shared ALU and one memory port.
// Holds the PC, instruction register, memory data register, two operand
// registers and the ALU result register. An external sequencer drives all
// selects and enables. Assumes 32-bit words and the fixed field layout
// opcode[31:26], rs[25:21], rt[20:16], rd[15:11], imm[15:0], funct[5:0].
module mc_datapath
    import mc_dp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pc_wr,
    input  logic        pc_wr_cond,
    input  logic        addr_sel,
    input  logic        ir_wr,
    input  logic        reg_wr,
    input  logic        dst_sel,
    input  logic        wb_sel,
    input  logic [1:0]  alu_mode,
    input  logic        src_a_sel,
    input  logic [1:0]  src_b_sel,
    input  logic [1:0]  pc_src,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [5:0]  opcode,
    output logic        alu_zero
);

    localparam int W       = WORD_W;
    localparam int IMM_W   = 16;
    localparam int JIDX_W  = 26;
    localparam int PC_HI_W = W - JIDX_W - 2;

    logic [W-1:0]      pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [W-1:0]      imm_ext, imm_x4, alu_a, alu_b, alu_res;
    logic [W-1:0]      pc_next, jump_tgt, rf_a, rf_b, rf_wdata;
    logic [REG_AW-1:0] rf_waddr;
    logic              pc_en;

    // Immediate extension and word scaling
    always_comb begin
        imm_ext  = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
        imm_x4   = {imm_ext[W-3:0], 2'b00};
        jump_tgt = {pc_q[W-1:W-PC_HI_W], ir_q[JIDX_W-1:0], 2'b00};
    end

    // ALU operand selection
    always_comb begin
        alu_a = src_a_sel ? a_q : pc_q;
        case (src_b_sel)
            SB_FOUR:   alu_b = W'(4);
            SB_IMM:    alu_b = imm_ext;
            SB_IMM_X4: alu_b = imm_x4;
            default:   alu_b = b_q;
        endcase
    end

    mc_alu #(.W(W)) u_alu (
        .a      (alu_a),
        .b      (alu_b),
        .mode   (alu_mode),
        .funct  (ir_q[FN_W-1:0]),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // Register write address and data selection
    always_comb begin
        rf_waddr = dst_sel ? ir_q[15:11] : ir_q[20:16];
        rf_wdata = wb_sel ? mdr_q : aluout_q;
    end

    mc_regfile #(.W(W), .DEPTH(REG_NUM)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (ir_q[25:21]),
        .rd_b_addr (ir_q[20:16]),
        .rd_a_data (rf_a),
        .rd_b_data (rf_b),
        .we        (reg_wr),
        .wr_addr   (rf_waddr),
        .wr_data   (rf_wdata)
    );

    // PC source selection and write qualification
    always_comb begin
        case (pc_src)
            PS_HELD: pc_next = aluout_q;
            PS_JUMP: pc_next = jump_tgt;
            default: pc_next = alu_res;
        endcase
        pc_en = pc_wr || (pc_wr_cond && alu_zero);
    end

    // Program counter
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_en) pc_q <= pc_next;
    end

    // Instruction register, loaded only on request
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_wr) ir_q <= mem_rdata;
    end

    // Inter-phase holding registers, loaded every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            mdr_q    <= mem_rdata;
            a_q      <= rf_a;
            b_q      <= rf_b;
            aluout_q <= alu_res;
        end
    end

    // Memory interface and opcode export
    always_comb begin
        mem_addr  = addr_sel ? aluout_q : pc_q;
        mem_wdata = b_q;
        opcode    = ir_q[31:26];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && ir_q == '0 && aluout_q == '0 && b_q == '0));

    // R2
    pc_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'b00 && !src_a_sel && src_b_sel == 2'b01 && alu_mode == 2'b00)
        |=> (pc_q == $past(pc_q) + 32'd4));

    // R6
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_wr || (pc_wr_cond && alu_zero)) |=> $stable(pc_q));

    // R11
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable(ir_q));

    // R8
    alu_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode == 2'b01) |-> (alu_res + alu_b == alu_a));

endmodule

// File: tb/mc_datapath_tb.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;

    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_wr = 0, pc_wr_cond = 0, addr_sel = 0, ir_wr = 0;
    logic        reg_wr = 0, dst_sel = 0, wb_sel = 0, src_a_sel = 0;
    logic [1:0]  alu_mode = 0, src_b_sel = 0, pc_src = 0;
    logic        mem_we = 0;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic [5:0]  opcode;
    logic        alu_zero;

    logic [31:0] mem [64];

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:2]];

    mc_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .addr_sel(addr_sel), .ir_wr(ir_wr), .reg_wr(reg_wr), .dst_sel(dst_sel),
        .wb_sel(wb_sel), .alu_mode(alu_mode), .src_a_sel(src_a_sel),
        .src_b_sel(src_b_sel), .pc_src(pc_src), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode),
        .alu_zero(alu_zero)
    );

    // Behavioural reference state
    logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_alo;
    logic [31:0] m_rf [32];

    function automatic logic [31:0] ref_alu(input logic [1:0] md, input logic [5:0] fn,
                                            input logic [31:0] x, input logic [31:0] y);
        integer sx, sy;
        sx = x; sy = y;
        if (md == 2'b01) return x - y;
        if (md != 2'b10) return x + y;
        if (fn == 6'h22) return x - y;
        if (fn == 6'h24) return x & y;
        if (fn == 6'h25) return x | y;
        if (fn == 6'h2A) return (sx < sy) ? 32'd1 : 32'd0;
        return x + y;
    endfunction

    function automatic logic [31:0] ref_result();
        logic [31:0] opa, opb, ext;
        ext = {{16{m_ir[15]}}, m_ir[15:0]};
        opa = src_a_sel ? m_a : m_pc;
        case (src_b_sel)
            2'b00: opb = m_b;
            2'b01: opb = 32'd4;
            2'b10: opb = ext;
            default: opb = ext * 4;
        endcase
        return ref_alu(alu_mode, m_ir[5:0], opa, opb);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One clock: advance the model at the edge, compare just after it
    task automatic tick(input string tag);
        logic [31:0] res, addr, rd, nxt_pc, dut_a, dut_d;
        logic [4:0]  wa;
        #1;
        dut_a = mem_addr;
        dut_d = mem_wdata;
        res  = ref_result();
        addr = addr_sel ? m_alo : m_pc;
        rd   = mem[addr[7:2]];
        case (pc_src)
            2'b01: nxt_pc = m_alo;
            2'b10: nxt_pc = {m_pc[31:28], m_ir[25:0], 2'b00};
            default: nxt_pc = res;
        endcase
        wa = dst_sel ? m_ir[15:11] : m_ir[20:16];
        @(posedge clk);
        if (!rst_n) begin
            m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_alo = 0;
            for (int i = 0; i < 32; i++) m_rf[i] = 0;
        end else begin
            if (mem_we) mem[dut_a[7:2]] = dut_d;
            m_a = m_rf[m_ir[25:21]];
            m_b = m_rf[m_ir[20:16]];
            if (reg_wr && wa != 0) m_rf[wa] = wb_sel ? m_mdr : m_alo;
            if (pc_wr || (pc_wr_cond && res == 0)) m_pc = nxt_pc;
            if (ir_wr) m_ir = rd;
            m_mdr = rd;
            m_alo = res;
        end
        #1;
        chk(tag, "mem_addr", mem_addr, addr_sel ? m_alo : m_pc);
        chk(tag, "mem_wdata", mem_wdata, m_b);
        chk(tag, "opcode", {26'd0, opcode}, {26'd0, m_ir[31:26]});
        chk(tag, "alu_zero", {31'd0, alu_zero}, {31'd0, ref_result() == 0});
        @(negedge clk);
    endtask

    localparam int U_FETCH = 0, U_DEC = 1, U_MADDR = 2, U_MEMRD = 3, U_MEMWB = 4;
    localparam int U_MEMWR = 5, U_REXEC = 6, U_RWB = 7, U_BEQ = 8, U_JUMP = 9;

    task automatic uop(input int k, input string tag);
        pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; ir_wr = 0; reg_wr = 0;
        dst_sel = 0; wb_sel = 0; src_a_sel = 0; alu_mode = 0; src_b_sel = 0;
        pc_src = 0; mem_we = 0;
        case (k)
            U_FETCH: begin ir_wr = 1; src_b_sel = 2'b01; pc_wr = 1; end
            U_DEC:   src_b_sel = 2'b11;
            U_MADDR: begin src_a_sel = 1; src_b_sel = 2'b10; addr_sel = 1; end
            U_MEMRD: addr_sel = 1;
            U_MEMWB: begin reg_wr = 1; wb_sel = 1; end
            U_MEMWR: begin addr_sel = 1; mem_we = 1; end
            U_REXEC: begin src_a_sel = 1; alu_mode = 2'b10; addr_sel = 1; end
            U_RWB:   begin reg_wr = 1; dst_sel = 1; end
            U_BEQ:   begin src_a_sel = 1; alu_mode = 2'b01; pc_wr_cond = 1; pc_src = 2'b01; end
            U_JUMP:  begin pc_src = 2'b10; pc_wr = 1; end
            default: ;
        endcase
        tick(tag);
    endtask

    task automatic do_r(input logic [31:0] exp, input string tag);
        uop(U_FETCH, "R2");
        uop(U_DEC, "R3");
        uop(U_REXEC, "R9");
        chk(tag, "execute result", mem_addr, exp);
        uop(U_RWB, "R7");
    endtask

    task automatic do_lw();
        uop(U_FETCH, "R2"); uop(U_DEC, "R3"); uop(U_MADDR, "R12");
        uop(U_MEMRD, "R4"); uop(U_MEMWB, "R7");
    endtask

    task automatic do_sw();
        uop(U_FETCH, "R2"); uop(U_DEC, "R3"); uop(U_MADDR, "R12"); uop(U_MEMWR, "R4");
    endtask

    task automatic do_reset();
        uop(-1, "R1");
        rst_n = 0;
        tick("R1");
        tick("R1");
        rst_n = 1;
    endtask

    function automatic logic [31:0] rty(input int rs, rt, rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] ity(input logic [5:0] op, input int rs, rt,
                                        input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        mem[0]  = ity(6'h23, 0, 1, 16'h0080);
        mem[1]  = ity(6'h23, 0, 2, 16'h0084);
        mem[2]  = rty(1, 2, 3, 6'h20);
        mem[3]  = rty(1, 2, 4, 6'h22);
        mem[4]  = rty(1, 2, 5, 6'h24);
        mem[5]  = rty(1, 2, 6, 6'h25);
        mem[6]  = rty(2, 1, 7, 6'h2A);
        mem[7]  = rty(1, 2, 8, 6'h2A);
        mem[8]  = rty(1, 2, 9, 6'h3F);
        mem[9]  = rty(1, 1, 0, 6'h20);
        mem[10] = ity(6'h2B, 0, 4, 16'h0088);
        mem[11] = ity(6'h2B, 0, 0, 16'h008C);
        mem[12] = ity(6'h04, 3, 9, 16'h0002);
        mem[15] = ity(6'h04, 1, 2, 16'h0005);
        mem[16] = {6'h02, 26'd20};
        mem[20] = ity(6'h23, 0, 10, 16'h0088);
        mem[21] = ity(6'h2B, 0, 10, 16'h0090);
        mem[32] = 32'd5;
        mem[33] = 32'hFFFF_FFFD;
        mem[34] = 32'h1111_1111;
        mem[35] = 32'h0000_DEAD;
        mem[36] = 32'h2222_2222;

        @(negedge clk);
        do_reset();
        chk("R1", "reset mem_addr", mem_addr, 32'd0);
        chk("R1", "reset mem_wdata", mem_wdata, 32'd0);
        chk("R1", "reset opcode", {26'd0, opcode}, 32'd0);

        // lw r1 with directed checks
        uop(U_FETCH, "R2");
        chk("R2", "PC after fetch", mem_addr, 32'd4);
        uop(U_DEC, "R3");
        uop(U_MADDR, "R12");
        chk("R12", "sign-extended address", mem_addr, 32'h80);
        uop(U_MEMRD, "R4");
        chk("R11", "opcode held with ir_wr low", {26'd0, opcode}, 32'h23);
        uop(U_MEMWB, "R7");
        do_lw();

        do_r(32'd2, "R8");
        do_r(32'd8, "R9");
        do_r(32'd5, "R9");
        do_r(32'hFFFF_FFFD, "R9");
        do_r(32'd1, "R9");
        do_r(32'd0, "R9");
        do_r(32'd2, "R9");
        do_r(32'd10, "R10");

        // sw r4: B observed after decode
        uop(U_FETCH, "R2");
        uop(U_DEC, "R3");
        chk("R3", "second operand after decode", mem_wdata, 32'd8);
        uop(U_MADDR, "R12");
        uop(U_MEMWR, "R4");
        chk("R4", "stored word", mem[34], 32'd8);

        do_sw();
        chk("R10", "register 0 stored", mem[35], 32'd0);

        // beq taken
        uop(U_FETCH, "R2"); uop(U_DEC, "R3"); uop(U_BEQ, "R6");
        chk("R8", "zero on equal operands", {31'd0, alu_zero}, 32'd1);
        chk("R5", "branch target", mem_addr, 32'h3C);

        // beq not taken
        uop(U_FETCH, "R2"); uop(U_DEC, "R3"); uop(U_BEQ, "R6");
        chk("R8", "zero on unequal operands", {31'd0, alu_zero}, 32'd0);
        chk("R6", "PC held when not taken", mem_addr, 32'h40);

        // jump
        uop(U_FETCH, "R2"); uop(U_DEC, "R3"); uop(U_JUMP, "R5");
        chk("R5", "jump target", mem_addr, 32'h50);

        do_lw();
        do_sw();
        chk("R7", "loaded value written back then stored", mem[36], 32'd8);

        do_reset();
        chk("R1", "second reset mem_addr", mem_addr, 32'd0);
        chk("R1", "second reset opcode", {26'd0, opcode}, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule